// File: doc/BRIEF.md
# Two-Wire Debug Host Serializer

This block sits on the host side of a debug link. It turns parallel four-wire test-port bit requests into traffic on two wires: a clock line that only the host drives, and one data line that both ends share. Each request carries a mode-select bit and a data-in bit, and produces one frame. A frame holds three slots in a fixed order: mode-select, data-in, data-out. A slot opens at each rising edge of the wire clock. The host drives the line in the first two slots. It releases the line in the third slot so that the target can return its bit, and it samples that bit just before the slot closes.

The wire clock is the system clock divided down. Each half of a wire-clock period lasts `HALF` system clocks. Between frames the clock rests high, so the target's reset override stays engaged, and the host drives the data line high. A frame opens with one low half-period of lead-in. Three full wire-clock periods follow, each a high half and then a low half. The returned bit comes back on a one-cycle response strobe. A request is taken only while the engine is idle. The engine is idle again in the same cycle that the response is presented, so frames can follow each other with a single idle cycle between them.

Top module: `dbgWireHost`

## Requirements
- R1: After reset the block is idle. In idle, wireClk=1, wireOe=1, wireDout=1, reqReady=1 and rspValid=0.
- R2: A request is taken at a rising system-clock edge where reqValid=1 and reqReady=1. Count the first cycle after that edge as k=0. reqReady stays 0 for cycles k=0 to 7*HALF-1. During those cycles the reqValid, reqTms and reqTdi inputs have no effect on the frame in flight.
- R3: Let p=k/HALF (integer division) for k from 0 to 7*HALF-1. In those cycles wireClk is 1 when p is odd and 0 when p is even. From k=7*HALF onward wireClk stays 1 until the next request is taken.
- R4: In cycles where p is 0, 1 or 2 (the lead-in and the mode-select slot), wireOe=1 and wireDout equals the reqTms value that was taken with the request.
- R5: In cycles where p is 3 or 4 (the data-in slot), wireDout equals the reqTdi value that was taken with the request. wireOe=1 there, except in the last cycle of the slot.
- R6: wireOe=0 from the last cycle of the data-in slot (k=5*HALF-1) through the end of the data-out slot (k=7*HALF-1). wireOe returns to 1 at k=7*HALF.
- R7: wireDin is sampled only at the edge that closes cycle k=7*HALF-1. rspValid=1 for cycle k=7*HALF alone, with rspTdo equal to that sample. The value of wireDin in any other cycle has no effect on rspTdo.
- R8: reqReady=1 in the cycle where rspValid=1, so a request held there is taken at the next edge and starts a new frame at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Engine idle and able to take a request |
| reqTms | input | 1 | Mode-select bit of the request |
| reqTdi | input | 1 | Data-in bit of the request |
| rspValid | output | 1 | One-cycle strobe marking the returned bit |
| rspTdo | output | 1 | Data-out bit sampled from the line |
| wireClk | output | 1 | Wire clock, high in idle |
| wireDout | output | 1 | Value the host drives onto the data line |
| wireOe | output | 1 | Host data driver enable, active high |
| wireDin | input | 1 | Data line as seen by the host |

## Verification
Every pin result is due at a known offset k after the edge that takes the request. The bench counts k from the first falling edge after that handshake and compares all pins at each falling edge against a function of k, `HALF` and the bits it offered. The response is due at exactly k=7*HALF: 28 system cycles after the taking edge with the default `HALF` of 4. The bench drives the true returned bit only during k=7*HALF-1 and the inverse bit in every other cycle, so a sample taken one cycle early or late shows up as a wrong rspTdo. While a frame runs, the bench keeps offering conflicting requests, which checks that busy-time inputs have no effect on the frame.

// File: rtl/dbgWirePkg.sv
package dbgWirePkg;

  typedef enum logic [2:0] {
    PH_LEAD  = 3'd0,
    PH_MSH   = 3'd1,
    PH_MSL   = 3'd2,
    PH_DIH   = 3'd3,
    PH_DIL   = 3'd4,
    PH_DOH   = 3'd5,
    PH_DOL   = 3'd6,
    PH_IDLE  = 3'd7
  } phase_t;

  typedef struct packed {
    logic load;
    logic clkHigh;
    logic driveTms;
    logic driveTdi;
    logic oe;
    logic sample;
  } strobe_t;

endpackage

// File: rtl/dbgWireCtrl.sv
module dbgWireCtrl
  import dbgWirePkg::*;
#(
  parameter int HALF = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  output logic    reqReady,
  output strobe_t st
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  phase_t phase;
  logic [CW-1:0] cnt;
  logic lastCnt;
  logic accept;

  assign lastCnt  = (cnt == LAST);
  assign reqReady = (phase == PH_IDLE);
  assign accept   = reqValid && reqReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (phase == PH_IDLE) begin
      if (accept) begin
        phase <= PH_LEAD;
        cnt   <= '0;
      end
    end else if (lastCnt) begin
      phase <= phase_t'(phase + 3'd1);
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    st          = '0;
    st.load     = accept;
    st.clkHigh  = phase[0];
    st.driveTms = (phase == PH_LEAD) || (phase == PH_MSH) || (phase == PH_MSL);
    st.driveTdi = (phase == PH_DIH) || (phase == PH_DIL);
    st.sample   = (phase == PH_DOL) && lastCnt;
    unique case (phase)
      PH_DIL:         st.oe = !lastCnt;
      PH_DOH, PH_DOL: st.oe = 1'b0;
      default:        st.oe = 1'b1;
    endcase
  end

endmodule

// File: rtl/dbgWireData.sv
module dbgWireData
  import dbgWirePkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  strobe_t st,
  input  logic    reqTms,
  input  logic    reqTdi,
  input  logic    wireDin,
  output logic    rspValid,
  output logic    rspTdo,
  output logic    wireClk,
  output logic    wireDout,
  output logic    wireOe
);

  logic tmsQ;
  logic tdiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmsQ     <= 1'b1;
      tdiQ     <= 1'b1;
      rspValid <= 1'b0;
      rspTdo   <= 1'b0;
    end else begin
      if (st.load) begin
        tmsQ <= reqTms;
        tdiQ <= reqTdi;
      end
      rspValid <= st.sample;
      if (st.sample) rspTdo <= wireDin;
    end
  end

  always_comb begin
    wireClk  = st.clkHigh;
    wireOe   = st.oe;
    if (st.driveTms)      wireDout = tmsQ;
    else if (st.driveTdi) wireDout = tdiQ;
    else                  wireDout = 1'b1;
  end

endmodule

// File: rtl/dbgWireHost.sv
module dbgWireHost
  import dbgWirePkg::*;
#(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  output logic reqReady,
  input  logic reqTms,
  input  logic reqTdi,
  output logic rspValid,
  output logic rspTdo,
  output logic wireClk,
  output logic wireDout,
  output logic wireOe,
  input  logic wireDin
);

  strobe_t st;

  dbgWireCtrl #(.HALF(HALF)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .st       (st)
  );

  dbgWireData uData (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .reqTms   (reqTms),
    .reqTdi   (reqTdi),
    .wireDin  (wireDin),
    .rspValid (rspValid),
    .rspTdo   (rspTdo),
    .wireClk  (wireClk),
    .wireDout (wireDout),
    .wireOe   (wireOe)
  );

endmodule

// File: rtl/dbgWireHostChk.sv
module dbgWireHostChk (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic reqReady,
  input logic rspValid,
  input logic wireClk,
  input logic wireOe
);

  // R1: the idle state holds the clock high with the line driven
  assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (wireClk && wireOe));

  // R3: a frame opens with the wire clock going low
  assert_lead_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !wireClk);

  // R6: the driver is released one cycle before the data-out slot opens
  assert_oe_gap_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wireOe) |=> $rose(wireClk));

  // R6: the line stays undriven only while the engine is busy
  assert_oe_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wireOe |-> !reqReady);

  // R7: the response strobe lasts a single cycle
  assert_rsp_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R8: the engine is idle again when the response appears
  assert_rsp_ready_R8: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (reqReady && wireOe && wireClk));

endmodule

bind dbgWireHost dbgWireHostChk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .rspValid (rspValid),
  .wireClk  (wireClk),
  .wireOe   (wireOe)
);

// File: tb/sim_dbgWireHost.sv
`timescale 1ns/100ps
module sim_dbgWireHost;

  localparam int HALF = 4;
  localparam int FLEN = 7 * HALF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqTms = 1'b0;
  logic reqTdi = 1'b0;
  logic wireDin = 1'b0;
  logic reqReady, rspValid, rspTdo, wireClk, wireDout, wireOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dbgWireHost #(.HALF(HALF)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqTms(reqTms), .reqTdi(reqTdi), .rspValid(rspValid), .rspTdo(rspTdo),
    .wireClk(wireClk), .wireDout(wireDout), .wireOe(wireOe), .wireDin(wireDin)
  );

  task automatic check1(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic expClk(int k);
    return ((k / HALF) % 2) == 1;
  endfunction

  function automatic logic expOe(int k);
    int p = k / HALF;
    if (p >= 5) return 1'b0;
    if (k == 5 * HALF - 1) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic expDout(int k, logic tms, logic tdi);
    int p = k / HALF;
    if (p <= 2) return tms;
    if (p <= 4) return tdi;
    return 1'b0;
  endfunction

  // Called at a falling edge with the engine idle; returns at the falling
  // edge of cycle k = FLEN (response cycle).
  task automatic doFrame(logic tms, logic tdi, logic tdo, bit noisy);
    reqValid = 1'b1;
    reqTms = tms;
    reqTdi = tdi;
    check1("R8", "ready before take", reqReady, 1'b1);
    @(negedge clk);
    for (int k = 0; k <= FLEN; k++) begin
      if (k > 0) @(negedge clk);
      if (noisy && k < FLEN - 1) begin
        reqValid = 1'b1;
        reqTms = $urandom_range(1, 0) != 0;
        reqTdi = $urandom_range(1, 0) != 0;
      end else begin
        reqValid = 1'b0;
      end
      wireDin = (k == FLEN - 1) ? tdo : ~tdo;
      if (k < FLEN) begin
        check1("R2", "ready busy", reqReady, 1'b0);
        check1("R3", "wire clock", wireClk, expClk(k));
        if (k < 5 * HALF - 1) check1((k < 3 * HALF) ? "R4" : "R5", "oe driven", wireOe, 1'b1);
        else check1("R6", "oe released", wireOe, expOe(k));
        if (k < 5 * HALF) check1((k < 3 * HALF) ? "R4" : "R5", "data", wireDout, expDout(k, tms, tdi));
        check1("R7", "no early response", rspValid, 1'b0);
      end else begin
        check1("R7", "response strobe", rspValid, 1'b1);
        check1("R7", "response bit", rspTdo, tdo);
        check1("R6", "oe restored", wireOe, 1'b1);
        check1("R3", "clock idle high", wireClk, 1'b1);
        check1("R8", "ready with response", reqReady, 1'b1);
      end
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic prevTdo;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check1("R1", "reset clock", wireClk, 1'b1);
    check1("R1", "reset oe", wireOe, 1'b1);
    check1("R1", "reset data", wireDout, 1'b1);
    check1("R1", "reset ready", reqReady, 1'b1);
    check1("R1", "reset rsp", rspValid, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check1("R1", "idle data", wireDout, 1'b1);

    // directed corners
    doFrame(1'b1, 1'b0, 1'b1, 1'b0);
    doFrame(1'b0, 1'b1, 1'b0, 1'b0); // back-to-back (R8)
    doFrame(1'b1, 1'b1, 1'b0, 1'b1); // busy-time noise (R2)
    @(negedge clk);
    check1("R7", "strobe one cycle", rspValid, 1'b0);
    check1("R1", "idle data high", wireDout, 1'b1);
    prevTdo = rspTdo;
    // din toggled while idle has no effect on held result
    wireDin = ~prevTdo;
    repeat (3) @(negedge clk);
    check1("R7", "din ignored idle", rspTdo, prevTdo);
    check1("R3", "clock rests high", wireClk, 1'b1);

    for (int i = 0; i < 40; i++) begin
      logic a = $urandom_range(1, 0) != 0;
      logic b = $urandom_range(1, 0) != 0;
      logic c = $urandom_range(1, 0) != 0;
      bit n = $urandom_range(1, 0) != 0;
      int gap = $urandom_range(3, 0);
      doFrame(a, b, c, n);
      for (int g = 0; g < gap; g++) @(negedge clk);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule